// File: doc/BRIEF.md
# Sensor-Emulating Register Bank

This block is the register file behind a serial-bus target that behaves like a simple sensor. A bus engine, not part of this block, turns bus transactions into a byte address, write data, a write strobe and a read strobe, all synchronous to the system clock. The block answers with one byte of read data.

The 256-byte address space has four kinds of region. Eight configuration bytes can be written and read back. Eight data bytes are read-only and change by themselves: a 16-bit LFSR overwrites one of them at a fixed interval, taking the registers in turn. A fixed eight-byte identity string sits at the top of the map. Every other address reads as zero. The LFSR is a stand-in that a real measurement frontend can replace later.

The read byte is captured on the clock edge where the read strobe is high and then held. An LFSR refresh that lands while the bus engine is shifting out a byte therefore cannot change that byte.

Top module: `sensor_regbank`

## Requirements
- R1: A write to address 0x00–0x07 stores `wrData` in that configuration register. A read of the same address issued on the next cycle returns the stored byte.
- R2: A write to any address from 0x08 to 0xFF leaves all configuration and data registers unchanged.
- R3: Reset, active low and asynchronous, does four things: it clears the configuration and data registers to 0x00, clears `rdData` to 0x00, loads the LFSR with 0xACE1 and restarts the refresh timer.
- R4: The LFSR shifts left by one on each refresh. The new bit 0 is the XOR of state bits 15, 13, 12 and 10, which gives the polynomial x^16+x^14+x^13+x^11+1. The refreshed register receives the low byte of the new state.
- R5: A refresh happens on every `REFRESH_CLKS`-th rising clock edge after reset is released, and the first one comes on edge number `REFRESH_CLKS`. Refreshes write data registers 0x08, 0x09, … 0x0F in that order and then wrap around to 0x08.
- R6: Reads of 0xF8 through 0xFF return 0x53, 0x45, 0x4E, 0x53, 0x4F, 0x52, 0x01, 0x00, in that address order.
- R7: A read of any address from 0x10 to 0xF7 returns 0x00.
- R8: `rdData` is loaded only on a rising edge where `rdEn` is high, and it holds its value on every other edge. If a read and a refresh of the same register fall on the same edge, the read returns the value from before the refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address |
| wrData | input | 8 | Byte to write |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe, one cycle per byte |
| rdData | output | 8 | Byte captured by the last read |

## Verification
The checker covers the properties that hold on every cycle:
- `rdData` holds between read strobes.
- The unmapped range reads as zero.
- Selected signature bytes read back correctly.
- Reset clears the read byte.
- A configuration write is returned by a read on the following cycle.

Other behaviour only shows over a scenario, so the bench checks it against an independent model of the refresh timer and LFSR. This covers the order in which refreshes visit the data registers, the exact LFSR values, writes to read-only or unmapped addresses being ignored, and the value returned when a read lands on the same edge as a refresh.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int REG_CNT   = 8;
  localparam int IDX_W     = $clog2(REG_CNT);
  localparam int LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;  // bits 15,13,12,10
  localparam int REGION_W  = ADDR_W - IDX_W;
  localparam logic [REGION_W-1:0] CFG_BASE  = '0;
  localparam logic [REGION_W-1:0] DATA_BASE = REGION_W'(1);
  localparam logic [REGION_W-1:0] SIG_BASE  = '1;

  typedef enum logic [1:0] {
    REG_CFG,
    REG_DATA,
    REG_SIG,
    REG_NONE
  } regionE;

  typedef struct packed {
    logic             cfgWe;
    logic [IDX_W-1:0] cfgIdx;
    logic             refresh;
    logic [IDX_W-1:0] refreshIdx;
    logic             rdLatch;
    regionE           rdRegion;
    logic [IDX_W-1:0] rdIdx;
  } srbStrobesT;

  function automatic logic [DATA_W-1:0] sigByte(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0: sigByte = 8'h53;
      3'd1: sigByte = 8'h45;
      3'd2: sigByte = 8'h4E;
      3'd3: sigByte = 8'h53;
      3'd4: sigByte = 8'h4F;
      3'd5: sigByte = 8'h52;
      3'd6: sigByte = 8'h01;
      default: sigByte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int REFRESH_CLKS = 25000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output srbStrobesT        strobes
);
  localparam int CNT_W = $clog2(REFRESH_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFRESH_CLKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] refIdx;
  logic             tick;
  regionE           region;

  assign tick = (tickCnt == CNT_LAST);

  // refresh timer and register pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      refIdx  <= '0;
    end else if (tick) begin
      tickCnt <= '0;
      refIdx  <= refIdx + IDX_W'(1);
    end else begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  // address decode by region
  always_comb begin
    case (addr[ADDR_W-1:IDX_W])
      CFG_BASE:  region = REG_CFG;
      DATA_BASE: region = REG_DATA;
      SIG_BASE:  region = REG_SIG;
      default:   region = REG_NONE;
    endcase
  end

  always_comb begin
    strobes.cfgWe      = wrEn && (region == REG_CFG);
    strobes.cfgIdx     = addr[IDX_W-1:0];
    strobes.refresh    = tick;
    strobes.refreshIdx = refIdx;
    strobes.rdLatch    = rdEn;
    strobes.rdRegion   = region;
    strobes.rdIdx      = addr[IDX_W-1:0];
  end
endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
#(
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  srbStrobesT        strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cfgRegs  [REG_CNT];
  logic [DATA_W-1:0] dataRegs [REG_CNT];
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;
  logic [DATA_W-1:0] rdMux;

  assign lfsrNext = {lfsrQ[LFSR_W-2:0], ^(lfsrQ & LFSR_TAPS)};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lfsrQ <= LFSR_SEED;
    else if (strobes.refresh) lfsrQ <= lfsrNext;
  end

  for (genvar i = 0; i < REG_CNT; i++) begin : g_regs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgRegs[i] <= '0;
      else if (strobes.cfgWe && strobes.cfgIdx == IDX_W'(i))
        cfgRegs[i] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        dataRegs[i] <= '0;
      else if (strobes.refresh && strobes.refreshIdx == IDX_W'(i))
        dataRegs[i] <= lfsrNext[DATA_W-1:0];
    end
  end

  always_comb begin
    case (strobes.rdRegion)
      REG_CFG:  rdMux = cfgRegs[strobes.rdIdx];
      REG_DATA: rdMux = dataRegs[strobes.rdIdx];
      REG_SIG:  rdMux = sigByte(strobes.rdIdx);
      default:  rdMux = '0;
    endcase
  end

  // byte captured on the read strobe, held until the next one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.rdLatch) rdData <= rdMux;
  end
endmodule

// File: rtl/sensor_regbank.sv
module sensor_regbank
  import srb_pkg::*;
#(
  parameter int                REFRESH_CLKS = 25000,
  parameter logic [LFSR_W-1:0] LFSR_SEED    = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData
);
  srbStrobesT strobes;

  srb_ctrl #(.REFRESH_CLKS(REFRESH_CLKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .strobes(strobes)
  );

  srb_datapath #(.LFSR_SEED(LFSR_SEED)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: rtl/srb_checker.sv
module srb_checker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] addr,
  input logic [7:0] wrData,
  input logic       wrEn,
  input logic       rdEn,
  input logic [7:0] rdData
);
  assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr < 8'h08) ##1 (rdEn && !wrEn && addr == $past(addr))
      |=> rdData == $past(wrData, 2));

  assert_reset_clear_R3: assert property (@(posedge clk)
    !rstN |=> rdData == 8'h00);

  assert_sig_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'hF8) |=> rdData == 8'h53);

  assert_sig_rev_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'hFE) |=> rdData == 8'h01);

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr >= 8'h10 && addr <= 8'hF7) |=> rdData == 8'h00);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind sensor_regbank srb_checker chk_i (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
  .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
);

// File: tb/sensor_regbank_tb.sv
module sensor_regbank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER        = 16;

  typedef struct {
    logic [7:0] addr;
    logic [7:0] exp;
    string      tag;
  } expT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;

  int compared = 0;
  int mismatched = 0;
  logic rdFired = 1'b0;
  bit   finished = 1'b0;
  expT  sbQ[$];

  // reference state, built from the requirements
  logic [15:0] lfsrM;
  logic [7:0]  cfgM  [8];
  logic [7:0]  dataM [8];
  int          cntM;
  int          idxM;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_regbank #(.REFRESH_CLKS(PER)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData)
  );

  function automatic logic [15:0] stepLfsr(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[13] ^ s[12] ^ s[10];
    return {s[14:0], fb};
  endfunction

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    logic [7:0] sig [8] = '{8'h53, 8'h45, 8'h4E, 8'h53, 8'h4F, 8'h52, 8'h01, 8'h00};
    if (a < 8'h08) return cfgM[a[2:0]];
    if (a < 8'h10) return dataM[a[2:0]];
    if (a >= 8'hF8) return sig[a[2:0]];
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrM <= 16'hACE1;
      cntM  <= 0;
      idxM  <= 0;
      for (int i = 0; i < 8; i++) begin
        cfgM[i]  <= 8'h00;
        dataM[i] <= 8'h00;
      end
    end else begin
      if (wrEn && addr < 8'h08) cfgM[addr[2:0]] <= wrData;
      if (cntM == PER - 1) begin
        cntM <= 0;
        lfsrM <= stepLfsr(lfsrM);
        dataM[idxM] <= stepLfsr(lfsrM) & 16'h00FF;
        idxM <= (idxM + 1) % 8;
      end else begin
        cntM <= cntM + 1;
      end
    end
  end

  always @(posedge clk) rdFired <= rdEn && rstN;

  // monitor: compare each captured byte with the queued expectation
  always @(negedge clk) begin
    if (rdFired && sbQ.size() > 0) begin
      expT e;
      e = sbQ.pop_front();
      compared++;
      if (rdData !== e.exp) begin
        mismatched++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", e.tag, e.addr, rdData, e.exp);
      end
    end
  end

  // driver tasks, called at a falling edge
  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, input string tag);
    expT e;
    e.addr = a; e.exp = modelRead(a); e.tag = tag;
    sbQ.push_back(e);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic directCheck(input logic [7:0] act, input logic [7:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    directCheck(rdData, 8'h00, "R3 rdData after reset");
    rstN = 1'b1;
    // R3: registers cleared, before the first refresh
    doRead(8'h00, "R3 cfg reset");
    doRead(8'h08, "R3 data reset");
    // R1: configuration writes and readback, boundary indices
    doWrite(8'h00, 8'hA5);
    doRead(8'h00, "R1 cfg0");
    doWrite(8'h07, 8'h3C);
    doRead(8'h07, "R1 cfg7");
    for (int i = 1; i < 7; i++) doWrite(8'(i), 8'(8'h10 * i + 1));
    for (int i = 0; i < 8; i++) doRead(8'(i), "R1 cfg sweep");
    // R2: writes to read-only, signature and unmapped space
    doWrite(8'h09, 8'hFF);
    doRead(8'h09, "R2 data write ignored");
    doWrite(8'hF9, 8'h00);
    doRead(8'hF9, "R2 sig write ignored");
    doWrite(8'h20, 8'h77);
    doRead(8'h20, "R2 unmapped write ignored");
    doWrite(8'h08, 8'h11);
    for (int i = 0; i < 8; i++) doRead(8'(i), "R2 cfg untouched");
    // R6 / R7
    for (int i = 0; i < 8; i++) doRead(8'hF8 + 8'(i), "R6 signature");
    doRead(8'h10, "R7 unmapped low edge");
    doRead(8'hF7, "R7 unmapped high edge");
    doRead(8'h80, "R7 unmapped middle");
    // R4 / R5: let refreshes run through more than one wrap
    repeat (PER * 11 + 3) @(negedge clk);
    for (int i = 0; i < 8; i++) doRead(8'h08 + 8'(i), "R4 R5 data sweep");
    // R8: a read on the same edge as a refresh returns the old byte
    while (cntM != PER - 1) @(negedge clk);
    doRead(8'h08 + 8'(idxM), "R8 read on refresh edge");
    doRead(8'h08 + 8'(idxM == 0 ? 7 : idxM - 1), "R8 refreshed value");
    // R8: the held byte survives refreshes
    doRead(8'h0B, "R8 before hold");
    held = rdData;
    repeat (PER * 3) @(negedge clk);
    directCheck(rdData, held, "R8 hold across refreshes");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule